// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between a core's store pipeline and the write port of a data cache. Stores arrive with a byte address, a size and data. They wait in a small queue that keeps program order, and they leave the queue one at a time, oldest first, whenever the memory port accepts one. The queue decouples the store pipeline from a slow write port while keeping the memory image in program order.

Every load is looked up against all stores still in the queue, in the same cycle, with no register on the path. Only the youngest store whose bytes overlap the load decides the outcome:

- If that store holds every byte of the load, the load is answered from the queue. The load may start at any byte offset inside the store.
- If it holds only some of the load's bytes, the load is told to stall until the overlapping stores have drained. Partial data is never merged.
- A load that overlaps no queued store goes straight to memory.

Accesses that straddle a 64-byte line take the slow path: they are never forwarded, and they are flagged.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the queue is empty: `wr_valid` is 0, `st_ready` is 1, and a load sees neither `ld_hit` nor `ld_stall`.
- R2: Sizes are coded on two bits as log2 of the byte count (0=1, 1=2, 2=4, 3=8 bytes). A store is accepted on a clock edge where `st_valid` and `st_ready` are both 1. `st_ready` is 0 while 4 entries are held. A store offered while `st_ready` is 0 is dropped and never reaches the write port.
- R3: `wr_valid` is 1 whenever the queue is not empty. The write port presents the oldest entry's address, size and data. That entry is removed on an edge where `wr_ready` is 1. While `wr_ready` is 0 the presented entry holds steady, and entries leave in acceptance order.
- R4: A valid load that overlaps no queued store gives `ld_hit`=0 and `ld_stall`=0.
- R5: Store data is little-endian: the byte at the store's address sits in `st_data[7:0]`. Suppose the youngest overlapping store contains every byte of the load, and neither that store nor the load crosses a line. Then `ld_hit`=1, `ld_stall`=0, and `ld_data` holds the load's bytes starting at bit 0, taken from byte offset (load address − store address) of the store. Upper bits are zero.
- R6: When several queued stores overlap a load, only the youngest in acceptance order decides hit, stall and data.
- R7: If the youngest overlapping store does not contain all the load's bytes, the load sees `ld_stall`=1 and `ld_hit`=0. The stall ends once the overlapping stores have drained.
- R8: A line is 64 bytes. An access crosses a line when (address mod 64) + bytes > 64. `wr_cross` flags a presented store that crosses, and `ld_cross` flags a valid load that crosses. An overlapping load is stalled, not forwarded, when either the load or the youngest overlapping store crosses.
- R9: `ld_data` is 0 whenever `ld_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| st_valid | input | 1 | store offered |
| st_ready | output | 1 | queue can take a store |
| st_addr | input | 16 | store byte address |
| st_size | input | 2 | store size code |
| st_data | input | 64 | store data, little-endian |
| wr_valid | output | 1 | oldest store presented to memory |
| wr_ready | input | 1 | memory takes the presented store |
| wr_addr | output | 16 | presented store address |
| wr_size | output | 2 | presented store size code |
| wr_data | output | 64 | presented store data |
| wr_cross | output | 1 | presented store crosses a line |
| ld_valid | input | 1 | load lookup request |
| ld_addr | input | 16 | load byte address |
| ld_size | input | 2 | load size code |
| ld_hit | output | 1 | load answered from the queue |
| ld_stall | output | 1 | load must wait for drain |
| ld_data | output | 64 | forwarded load data |
| ld_cross | output | 1 | load crosses a line |

## Verification
A corrupted head pointer or count appears on the write port at the next drain. It shows as a store out of order, a repeated store, or a lost store, and it shows on `st_ready` as soon as the fourth store is accepted. A wrong age rank or containment compare shows in the same cycle as the load. It appears as a hit where a stall belongs, or as bytes from an older store or from the wrong offset. Sweeping every load address and size around queued stores exposes such faults at once.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int unsigned SB_AW         = 16;
    localparam int unsigned SB_DW         = 64;
    localparam int unsigned SB_LINE_BYTES = 64;
    localparam int unsigned SB_DEPTH      = 4;

    typedef logic [1:0] size_code_t;

    typedef struct packed {
        logic [SB_AW-1:0] addr;
        size_code_t       size;
        logic [SB_DW-1:0] data;
    } sb_entry_t;

    // byte count of a size code, one bit wider than an address
    function automatic logic [SB_AW:0] nbytes(input size_code_t s);
        return (SB_AW+1)'(1) << s;
    endfunction

    function automatic logic [SB_AW:0] end_addr(input logic [SB_AW-1:0] a, input size_code_t s);
        return {1'b0, a} + nbytes(s);
    endfunction

    function automatic logic crosses_line(input logic [SB_AW-1:0] a, input size_code_t s);
        logic [SB_AW:0] off;
        off = {1'b0, a} & (SB_AW+1)'(SB_LINE_BYTES - 1);
        return (off + nbytes(s)) > (SB_AW+1)'(SB_LINE_BYTES);
    endfunction

    function automatic logic [SB_DW-1:0] lane_mask(input size_code_t s);
        logic [SB_DW-1:0] m;
        m = '0;
        for (int b = 0; b < SB_DW/8; b++)
            if ((SB_AW+1)'(b) < nbytes(s)) m[8*b +: 8] = 8'hFF;
        return m;
    endfunction
endpackage

// File: rtl/sb_queue.sv
module sb_queue
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = SB_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  sb_entry_t                push_entry,
    input  logic                     pop,
    output sb_entry_t                ordered [DEPTH],
    output logic [DEPTH-1:0]         ord_valid,
    output logic                     full,
    output logic                     empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    sb_entry_t        slots [DEPTH];
    logic [PW-1:0]    head, tail;
    logic [CW-1:0]    count;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                slots[tail] <= push_entry;
                tail        <= tail + PW'(1);
            end
            if (pop) head <= head + PW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // age-ordered view: position 0 is the oldest entry
    for (genvar k = 0; k < DEPTH; k++) begin : g_order
        logic [PW-1:0] idx;
        assign idx          = head + PW'(k);
        assign ordered[k]   = slots[idx];
        assign ord_valid[k] = (CW'(k) < count);
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    assert_no_push_when_full_R2: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);
    assert_no_pop_when_empty_R3: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);
endmodule

// File: rtl/sb_match.sv
module sb_match
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = SB_DEPTH
) (
    input  sb_entry_t              ordered [DEPTH],
    input  logic [DEPTH-1:0]       ord_valid,
    input  logic [SB_AW-1:0]       ld_addr,
    input  size_code_t             ld_size,
    output logic [DEPTH-1:0]       overlap,
    output logic [DEPTH-1:0]       contain,
    output logic [DEPTH-1:0]       st_cross
);
    logic [SB_AW:0] ld_lo, ld_hi;
    assign ld_lo = {1'b0, ld_addr};
    assign ld_hi = end_addr(ld_addr, ld_size);

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        logic [SB_AW:0] s_lo, s_hi;
        assign s_lo        = {1'b0, ordered[k].addr};
        assign s_hi        = end_addr(ordered[k].addr, ordered[k].size);
        assign overlap[k]  = ord_valid[k] && (ld_lo < s_hi) && (s_lo < ld_hi);
        assign contain[k]  = ord_valid[k] && (ld_lo >= s_lo) && (ld_hi <= s_hi);
        assign st_cross[k] = crosses_line(ordered[k].addr, ordered[k].size);
    end
endmodule

// File: rtl/sb_pick.sv
module sb_pick
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = SB_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  sb_entry_t             ordered [DEPTH],
    input  logic [DEPTH-1:0]      overlap,
    input  logic [DEPTH-1:0]      contain,
    input  logic [DEPTH-1:0]      st_cross,
    input  logic                  ld_valid,
    input  logic [SB_AW-1:0]      ld_addr,
    input  size_code_t            ld_size,
    input  logic                  ld_cross,
    output logic                  ld_hit,
    output logic                  ld_stall,
    output logic [SB_DW-1:0]      ld_data
);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IW-1:0]    young;
    logic             any_ov;
    logic             fwd_ok;
    logic [SB_AW-1:0] offset;
    logic [SB_DW-1:0] shifted;

    always_comb begin
        young  = '0;
        any_ov = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (overlap[k]) begin
                young  = IW'(k);
                any_ov = 1'b1;
            end
        end
    end

    assign fwd_ok   = any_ov && contain[young] && !st_cross[young] && !ld_cross;
    assign ld_hit   = ld_valid && fwd_ok;
    assign ld_stall = ld_valid && any_ov && !fwd_ok;
    assign offset   = ld_addr - ordered[young].addr;
    assign shifted  = ordered[young].data >> {offset, 3'b000};
    assign ld_data  = ld_hit ? (shifted & lane_mask(ld_size)) : '0;

    assert_hit_stall_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(ld_hit && ld_stall));
    assert_no_hit_when_crossing_R8: assert property (@(posedge clk) disable iff (rst)
        ld_cross |-> !ld_hit);
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = SB_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [SB_AW-1:0]  st_addr,
    input  logic [1:0]        st_size,
    input  logic [SB_DW-1:0]  st_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [SB_AW-1:0]  wr_addr,
    output logic [1:0]        wr_size,
    output logic [SB_DW-1:0]  wr_data,
    output logic              wr_cross,
    input  logic              ld_valid,
    input  logic [SB_AW-1:0]  ld_addr,
    input  logic [1:0]        ld_size,
    output logic              ld_hit,
    output logic              ld_stall,
    output logic [SB_DW-1:0]  ld_data,
    output logic              ld_cross
);
    sb_entry_t        ordered [DEPTH];
    logic [DEPTH-1:0] ord_valid, overlap, contain, st_cross;
    logic             full, empty, push, pop;
    sb_entry_t        in_entry;

    assign st_ready = !full;
    assign push     = st_valid && st_ready;
    assign wr_valid = !empty;
    assign pop      = wr_valid && wr_ready;
    assign in_entry = '{addr: st_addr, size: st_size, data: st_data};

    sb_queue #(.DEPTH(DEPTH)) i_queue (
        .clk(clk), .rst(rst), .push(push), .push_entry(in_entry), .pop(pop),
        .ordered(ordered), .ord_valid(ord_valid), .full(full), .empty(empty)
    );

    assign wr_addr  = ordered[0].addr;
    assign wr_size  = ordered[0].size;
    assign wr_data  = ordered[0].data;
    assign wr_cross = wr_valid && st_cross[0];
    assign ld_cross = ld_valid && crosses_line(ld_addr, ld_size);

    sb_match #(.DEPTH(DEPTH)) i_match (
        .ordered(ordered), .ord_valid(ord_valid), .ld_addr(ld_addr), .ld_size(ld_size),
        .overlap(overlap), .contain(contain), .st_cross(st_cross)
    );

    sb_pick #(.DEPTH(DEPTH)) i_pick (
        .clk(clk), .rst(rst), .ordered(ordered), .overlap(overlap), .contain(contain),
        .st_cross(st_cross), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
        .ld_cross(ld_cross), .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data)
    );

    assert_wr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_size)));
    assert_ready_when_empty_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> st_ready);
    assert_data_zero_on_miss_R9: assert property (@(posedge clk) disable iff (rst)
        !ld_hit |-> (ld_data == '0));
endmodule

// File: tb/test_store_fwd_buffer.sv
module test_store_fwd_buffer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst = 1;
    logic        st_valid = 0, wr_ready = 0, ld_valid = 0;
    logic [15:0] st_addr = 0, ld_addr = 0;
    logic [1:0]  st_size = 0, ld_size = 0;
    logic [63:0] st_data = 0;
    logic        st_ready, wr_valid, wr_cross, ld_hit, ld_stall, ld_cross;
    logic [15:0] wr_addr;
    logic [1:0]  wr_size;
    logic [63:0] wr_data, ld_data;

    int checks = 0, errors = 0;

    // bench model of queued stores, index 0 oldest
    int          m_n = 0;
    int          m_a [8];
    int          m_s [8];
    logic [63:0] m_d [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    store_fwd_buffer i_store_fwd_buffer (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input int a, input int s, input logic [63:0] d);
        @(negedge clk);
        st_valid = 1; st_addr = 16'(a); st_size = 2'(s); st_data = d;
        if (st_ready) begin
            m_a[m_n] = a; m_s[m_n] = s; m_d[m_n] = d; m_n++;
        end
        @(negedge clk);
        st_valid = 0;
    endtask

    task automatic drain_one(input string req);
        @(negedge clk);
        wr_ready = 1;
        #1;
        check(req, {63'd0, wr_valid}, 64'd1);
        check(req, {48'd0, wr_addr}, 64'(m_a[0]));
        check(req, {62'd0, wr_size}, 64'(m_s[0]));
        check(req, wr_data, m_d[0]);
        check(req, {63'd0, wr_cross}, {63'd0, ((m_a[0] % 64) + (1 << m_s[0])) > 64});
        @(negedge clk);
        wr_ready = 0;
        for (int i = 0; i + 1 < m_n; i++) begin
            m_a[i] = m_a[i+1]; m_s[i] = m_s[i+1]; m_d[i] = m_d[i+1];
        end
        m_n--;
    endtask

    task automatic probe(input int a, input int s, input string req);
        int  y, n;
        logic ov, xl, xs, cont, hit, stall;
        logic [63:0] exp_d;
        n = 1 << s;
        y = -1;
        for (int k = 0; k < m_n; k++)
            if (a < m_a[k] + (1 << m_s[k]) && m_a[k] < a + n) y = k;
        ov    = (y >= 0);
        xl    = ((a % 64) + n) > 64;
        xs    = ov && (((m_a[y] % 64) + (1 << m_s[y])) > 64);
        cont  = ov && a >= m_a[y] && a + n <= m_a[y] + (1 << m_s[y]);
        hit   = ov && cont && !xs && !xl;
        stall = ov && !hit;
        exp_d = 0;
        if (hit) begin
            exp_d = m_d[y] >> (8 * (a - m_a[y]));
            if (n < 8) exp_d = exp_d & ((64'd1 << (8 * n)) - 1);
        end
        ld_valid = 1; ld_addr = 16'(a); ld_size = 2'(s);
        #1;
        check(req, {63'd0, ld_hit}, {63'd0, hit});
        check(req, {63'd0, ld_stall}, {63'd0, stall});
        check(req, ld_data, exp_d);
        check("R8", {63'd0, ld_cross}, {63'd0, xl});
        ld_valid = 0;
    endtask

    task automatic sweep(input int lo, input int hi, input string req);
        @(negedge clk);
        for (int a = lo; a <= hi; a++)
            for (int s = 0; s < 4; s++)
                probe(a, s, req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        check("R1", {63'd0, wr_valid}, 64'd0);
        check("R1", {63'd0, st_ready}, 64'd1);
        probe(10, 2, "R1");

        // R5 R4 R7 R9: single 4-byte store at 10, every load around it
        push(10, 2, 64'h0000_0000_DDCC_BBAA);
        sweep(0, 20, "R5_R4_R7_R9");

        // R6: younger 2-byte store at 12 shadows part of the older one
        push(12, 1, 64'h0000_0000_0000_2211);
        sweep(6, 18, "R6");
        probe(10, 1, "R6");   // only older store overlaps: forward from it
        probe(11, 1, "R6");   // youngest overlap partial: stall

        // R8: crossing store at 62 (62..65) and a line-local one at 56
        push(56, 3, 64'h8877_6655_4433_2211);
        push(62, 2, 64'h0000_0000_A3A2_A1A0);
        sweep(52, 70, "R8");

        // R2: full queue rejects a fifth store
        check("R2", {63'd0, st_ready}, 64'd0);
        push(200, 0, 64'h55);
        check("R2", 64'(m_n), 64'd4);

        // R3: drain in order; R7: stall clears as stores leave
        drain_one("R3");
        sweep(8, 14, "R7");
        drain_one("R3");
        probe(11, 1, "R7");
        drain_one("R3");
        drain_one("R3");
        #1;
        check("R3", {63'd0, wr_valid}, 64'd0);
        check("R2", {63'd0, st_ready}, 64'd1);
        probe(9, 2, "R7");
        sweep(60, 66, "R4");

        // R3: hold while memory refuses, then drain
        push(100, 3, 64'h0123_4567_89AB_CDEF);
        push(108, 0, 64'h7E);
        repeat (3) @(negedge clk);
        #1;
        check("R3", {48'd0, wr_addr}, 64'd100);
        sweep(98, 110, "R5");
        drain_one("R3");
        drain_one("R3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule